// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences read and write cycles on a narrow external static-memory port. The core issues a request carrying an address, write data and a direction. The controller puts the address on the bus and lowers the matching active-low strobe. It keeps the strobe low until two conditions hold: a programmed minimum number of wait states has elapsed, and the external transfer-acknowledge input has been seen. It then releases the strobe and pulses a done signal back to the core for one clock.

The acknowledge input can be sampled directly, which suits a device clocked from the same source. It can also pass through a synchronizer chain first, which suits a device with its own timing. A cycle programmed with zero wait states always lasts one strobe clock, and the acknowledge has no effect on it.

In standby the output enables of the strobes and the data bus drop, so the port floats. The address bus keeps its last value between cycles, so idle periods cause no toggling on it.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: While reset is asserted, rd_n and wr_n are high, ctl_oe, data_oe and done are low, and bus_addr is zero.
- R2: With wait_min equal to zero, the strobe is low for exactly one clock, whatever the state of ack_n.
- R3: With wait_min equal to W greater than zero and ack_n held low (asserted) from before the request, the strobe is low for W+1 clocks.
- R4: In direct mode (ack_async=0), the cycle is extended by ack_n (active low). If ack_n is first sampled low at the k-th rising edge after the strobe falls, the strobe is low for max(W,k)+1 clocks. While ack_n stays high the strobe stays low without limit.
- R5: In synchronized mode (ack_async=1), ack_n passes through SYNC_STAGES flops before it is used. A low level first driven before the edge k-SYNC_STAGES therefore acts as if sampled at edge k in the R4 formula.
- R6: While no cycle is in progress, activity on ack_n produces no strobe and no done pulse, and leaves bus_addr unchanged.
- R7: done is high for exactly the one clock that follows the last strobe-low clock. In that clock both strobes are high and no new request is accepted.
- R8: A write (req_write=1) lowers only wr_n. data_oe is high exactly while wr_n is low, and data_out then carries the request's write data.
- R9: A read (req_write=0) lowers only rd_n and keeps data_oe low. When done is high, rdata holds the value that data_in had during the last rd_n-low clock.
- R10: bus_addr takes the request address in the clock in which the strobe falls, and holds it after the cycle until the next request.
- R11: One clock after standby is raised, ctl_oe and data_oe are low. Requests presented during standby are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe from the core, sampled while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| wait_min | input | WS_W | Minimum wait-state count for the cycle |
| ack_n | input | 1 | External transfer acknowledge, active low |
| ack_async | input | 1 | 1 = synchronize ack_n before use |
| standby | input | 1 | Low-power standby; floats the port |
| bus_addr | output | ADDR_W | External address bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Output enable for the strobes |
| data_out | output | DATA_W | Data bus outgoing value |
| data_oe | output | 1 | Data bus output enable |
| data_in | input | DATA_W | Data bus incoming value |
| rdata | output | DATA_W | Captured read data, valid with done |
| done | output | 1 | One-clock cycle completion pulse |

## Verification
The assertions assume that wait_min, req_write and ack_async stay stable from the request until done. They also assume that standby is raised only while the port is idle, and that the core does not present a request before done of the previous one. The bench sets these inputs several idle clocks before each request and changes them only after the gap clock. It releases ack_n at done and then waits long enough for the synchronizer chain to clear, so no stale acknowledge leaks into the next cycle. The random cycles mix wait counts, acknowledge delays, both acknowledge modes and both directions. Directed cases cover the zero-wait exemption, idle acknowledge toggling and standby.

// File: rtl/xbus_pkg.sv
// Package: shared types of the external bus wait-state controller.
// Assumes: nothing beyond a synthesizable enum encoding.
package xbus_pkg;

    // Phase of the external bus cycle sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // waiting for a request
        PH_STROBE = 2'd1,  // strobe low, counting waits
        PH_GAP    = 2'd2   // one idle clock, done pulse
    } xbus_phase_e;

endpackage

// File: rtl/xbus_ack_sync.sv
// Module: xbus_ack_sync
// Turns the active-low external acknowledge into an active-high hit.
// In direct mode the raw pin is used as-is. In synchronized mode it
// passes through a STAGES-deep flop chain first.
// Assumes: STAGES >= 1; the direct path is only used with a pin that
// meets setup timing to clk.
module xbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    input  logic use_sync,
    output logic ack_hit
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= ~ack_n;
            end
        end else begin : g_chain
            // Shift the inverted pin through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], ~ack_n};
            end
        end
    endgenerate

    // Select the raw or the synchronized acknowledge.
    always_comb begin
        ack_hit = use_sync ? chain_q[STAGES-1] : ~ack_n;
    end

endmodule

// File: rtl/xbus_wait_seq.sv
// Module: xbus_wait_seq
// Cycle sequencer. It accepts a request while idle and holds the strobe
// phase until the latched minimum wait count is met and, for a non-zero
// count, an acknowledge has been seen. It then spends one gap clock
// with done high, capturing read data on the terminating edge.
// Assumes: the core waits for done before the next request.
module xbus_wait_seq
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WS_W-1:0]   wait_min,
    input  logic              standby,
    input  logic              ack_hit,
    input  logic [DATA_W-1:0] data_in,
    output logic              accept,
    output logic              in_strobe,
    output logic              cyc_write,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    xbus_phase_e       phase_q;
    logic [WS_W-1:0]   cnt_q;
    logic [WS_W-1:0]   wmin_q;
    logic              wr_q;
    logic              ack_seen_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic              min_met;
    logic              finish;

    // Decode when the request is taken and when the strobe may end.
    always_comb begin
        accept  = (phase_q == PH_IDLE) && req_valid && !standby;
        min_met = (cnt_q >= wmin_q);
        finish  = (phase_q == PH_STROBE) && min_met &&
                  ((wmin_q == '0) || ack_seen_q);
    end

    // Phase register and cycle bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            wmin_q     <= '0;
            wr_q       <= 1'b0;
            ack_seen_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    done_q <= 1'b0;
                    if (accept) begin
                        phase_q    <= PH_STROBE;
                        cnt_q      <= '0;
                        wmin_q     <= wait_min;
                        wr_q       <= req_write;
                        ack_seen_q <= 1'b0;
                    end
                end
                PH_STROBE: begin
                    if (finish) begin
                        phase_q <= PH_GAP;
                        done_q  <= 1'b1;
                    end else begin
                        if (!min_met) cnt_q <= cnt_q + 1'b1;
                        ack_seen_q <= ack_seen_q | ack_hit;
                    end
                end
                PH_GAP: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b0;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b0;
                end
            endcase
        end
    end

    // Read data capture on the edge that ends a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              rdata_q <= '0;
        else if (finish && !wr_q) rdata_q <= data_in;
    end

    // Output decode from the registered state.
    always_comb begin
        in_strobe = (phase_q == PH_STROBE);
        cyc_write = wr_q;
        done      = done_q;
        rdata     = rdata_q;
    end

endmodule

// File: rtl/xbus_pad_ctrl.sv
// Module: xbus_pad_ctrl
// Pin-side logic: holds the address and write data latched at accept,
// forms the active-low strobes and the output enables.
// Assumes: in_strobe and cyc_write come from registers, so the strobes
// do not glitch.
module xbus_pad_ctrl #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              standby,
    input  logic              in_strobe,
    input  logic              cyc_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              oe_q;

    // Address and write data: loaded at accept, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Pin enable follows standby one clock later; off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= !standby;
    end

    // Strobes and data enable from the sequencer phase.
    always_comb begin
        bus_addr = addr_q;
        data_out = wdata_q;
        rd_n     = !(in_strobe && !cyc_write);
        wr_n     = !(in_strobe && cyc_write);
        ctl_oe   = oe_q;
        data_oe  = oe_q && in_strobe && cyc_write;
    end

endmodule

// File: rtl/xbus_wait_ctrl.sv
// Module: xbus_wait_ctrl (top)
// External static-memory bus controller with programmable minimum wait
// states and an acknowledge that can stretch a cycle without limit.
// Assumes: synchronous active-low reset; one request per done.
module xbus_wait_ctrl #(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int WS_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   wait_min,
    input  logic              ack_n,
    input  logic              ack_async,
    input  logic              standby,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ctl_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic ack_hit;
    logic accept;
    logic in_strobe;
    logic cyc_write;

    xbus_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (ack_n),
        .use_sync (ack_async),
        .ack_hit  (ack_hit)
    );

    xbus_wait_seq #(.DATA_W(DATA_W), .WS_W(WS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .wait_min  (wait_min),
        .standby   (standby),
        .ack_hit   (ack_hit),
        .data_in   (data_in),
        .accept    (accept),
        .in_strobe (in_strobe),
        .cyc_write (cyc_write),
        .done      (done),
        .rdata     (rdata)
    );

    xbus_pad_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .standby   (standby),
        .in_strobe (in_strobe),
        .cyc_write (cyc_write),
        .bus_addr  (bus_addr),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ctl_oe    (ctl_oe),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
// Module: xbus_wait_ctrl_chk
// Property checker bound to the top. It watches the pins only.
// Assumes: wait_min is stable for the length of each cycle.
module xbus_wait_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int WS_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WS_W-1:0]   wait_min,
    input logic              standby,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ctl_oe,
    input logic              data_oe,
    input logic              done
);

    logic            strobe_low;
    logic [WS_W:0]   low_cnt_q;

    // Either strobe asserted.
    always_comb strobe_low = !rd_n || !wr_n;

    // Number of strobe-low clocks before the current one, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               low_cnt_q <= '0;
        else if (!strobe_low)     low_cnt_q <= '0;
        else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 1'b1;
    end

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_data_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !wr_n);

    p_zero_wait_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_low) && (wait_min == '0)) |=> !strobe_low);

    p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_low && (low_cnt_q < {1'b0, wait_min})) |=> strobe_low);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!strobe_low && $past(strobe_low)));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_addr) |-> strobe_low);

    p_standby_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!ctl_oe && !data_oe));

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_min (wait_min),
    .standby  (standby),
    .bus_addr (bus_addr),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ctl_oe   (ctl_oe),
    .data_oe  (data_oe),
    .done     (done)
);

// File: tb/xbus_wait_ctrl_test.sv
// Bench: random and directed cycles against lengths computed from the
// requirements; outputs sampled on the falling clock edge.
module xbus_wait_ctrl_test;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int WS_W   = 4;
    localparam int SYNC   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [WS_W-1:0]   wait_min = '0;
    logic              ack_n = 1'b1;
    logic              ack_async = 1'b0;
    logic              standby = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic              rd_n, wr_n, ctl_oe, data_oe, done;
    logic [DATA_W-1:0] data_out, rdata;
    logic [DATA_W-1:0] data_in = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xbus_wait_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W),
                     .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_min(wait_min),
        .ack_n(ack_n), .ack_async(ack_async), .standby(standby),
        .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe),
        .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
        .rdata(rdata), .done(done)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Strobe length from the requirements (d < 0: ack asserted beforehand).
    function automatic int exp_len(input int w, input int d, input bit asy);
        int k;
        if (w == 0) return 1;
        if (d < 0)  k = 1;
        else        k = asy ? d + 1 + SYNC : d + 1;
        return ((w > k) ? w : k) + 1;
    endfunction

    task automatic run_cycle(input bit wr, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] wd, input int w,
                             input int d, input bit asy);
        int len = 0;
        int bad = 0;
        logic [DATA_W-1:0] lastv;
        string rq;
        rq = (w == 0) ? "R2" : (d < 0) ? "R3" : asy ? "R5" : "R4";
        ack_async = asy;
        wait_min  = w[WS_W-1:0];
        ack_n     = (d < 0) ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lastv = data_in;
        while ((!rd_n || !wr_n) && len < 200) begin
            if (wr && (wr_n || !rd_n || !data_oe || data_out != wd)) bad++;
            if (!wr && (rd_n || !wr_n || data_oe)) bad++;
            if (bus_addr != a || !ctl_oe) bad++;
            len++;
            if (!wr) begin
                lastv = DATA_W'($urandom);
                data_in = lastv;
            end
            if (d >= 0 && len - 1 == d) ack_n = 1'b0;
            @(negedge clk);
        end
        check(len == exp_len(w, d, asy), rq, len, exp_len(w, d, asy));
        check(done == 1'b1, "R7", int'(done), 1);
        if (wr) check(bad == 0, "R8", bad, 0);
        else begin
            check(bad == 0, "R9", bad, 0);
            check(rdata == lastv, "R9", int'(rdata), int'(lastv));
        end
        check(bus_addr == a, "R10", int'(bus_addr), int'(a));
        ack_n = 1'b1;
        @(negedge clk);
        check(!done && rd_n && wr_n, "R7", int'(done), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_n && wr_n, "R1", int'({rd_n, wr_n}), 3);
        check(!ctl_oe && !data_oe && !done, "R1", int'({ctl_oe, data_oe, done}), 0);
        check(bus_addr == '0, "R1", int'(bus_addr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed corners.
        run_cycle(1'b1, 18'h00012, 8'hA5, 0, 20, 1'b0); // R2 zero wait, no ack
        run_cycle(1'b0, 18'h00013, 8'h00, 0, -1, 1'b1); // R2 with ack low
        run_cycle(1'b1, 18'h3FFFF, 8'h5A, 3, -1, 1'b0); // R3
        run_cycle(1'b0, 18'h01234, 8'h00, 2, 5, 1'b0);  // R4 ack dominates
        run_cycle(1'b0, 18'h04321, 8'h00, 6, 1, 1'b0);  // R4 minimum dominates
        run_cycle(1'b1, 18'h00777, 8'hC3, 1, 0, 1'b1);  // R5 sync delay
        run_cycle(1'b0, 18'h00888, 8'h00, 15, 0, 1'b1); // R5 max count

        // R6: ack activity while idle
        held = bus_addr;
        for (int i = 0; i < 6; i++) begin
            ack_n = i[0];
            @(negedge clk);
            check(rd_n && wr_n && !done && bus_addr == held, "R6",
                  int'({rd_n, wr_n, done}), 6);
        end
        ack_n = 1'b1;

        // R11: standby floats the port and blocks requests
        standby = 1'b1;
        @(negedge clk);
        check(!ctl_oe && !data_oe, "R11", int'({ctl_oe, data_oe}), 0);
        req_write = 1'b1; req_addr = 18'h2AAAA; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_n && wr_n && !done && bus_addr == held, "R11",
              int'(bus_addr), int'(held));
        standby = 1'b0;
        @(negedge clk);
        check(ctl_oe, "R11", int'(ctl_oe), 1);

        // Random cycles.
        for (int n = 0; n < 40; n++) begin
            run_cycle(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom),
                      int'($urandom_range(0, 5)), int'($urandom_range(0, 7)) - 1,
                      1'($urandom));
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule